// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the register file of a small LCD controller. A processor reaches it over a plain 32-bit bus made of an address, write data, a select and a write enable. Read data is a combinational function of the address. The block holds one control word, two dimension words, one timing word, a read-only status word and a sub-panel word. It drives the panel configuration held in those registers straight to the display engine.

The display engine reports three events by pulsing input lines: frame finished, palette loaded and sync error. Each event sets a sticky flag. The flags are combined into one level interrupt under two enable bits. Sync error is the exception and always interrupts.

When a control write changes the enable bit, the block emits a one-cycle start pulse or stop pulse to the engine. The same write forces the flags to new values.

Top module: `lcd_reg_unit`

## Requirements
- R1: A write to offset 0x00 stores the following fields, which drive `palMode`, `tftMode`, `monoMode` and `panelOn` from the next cycle:
  - enable from bit 0
  - mono from bit 1
  - interrupt enables from bits 4:3
  - TFT from bit 7
  - palette-load mode from bits 21:20
  - the bits under mask 0x01CFF300, kept as they are
- R2: Reading offset 0x00 returns the OR of these terms:
  - the kept bits
  - each field in its write position
  - a second copy of TFT at bit 23
  - the constant 0xFE000C34
- R3: Offsets 0x04 and 0x08 hold width-1 and height-1 in bits 9:0, which drive `pixWidthM1` and `pixHeightM1`, and keep bits 31:10. A read of 0x04 returns bits 3:0 forced to one.
- R4: Offset 0x0C stores all 32 bits and reads back ORed with 0xFC000000. Offset 0x14 stores the written value ANDed with 0xA1FFFFFF.
- R5: Offset 0x10 reads palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0, with zeros elsewhere. Writes to 0x10 change nothing.
- R6: Any other offset reads zero, and a write to it changes no register.
- R7: `irqOut` is a register. In the cycle after the flags are sampled it is high if any of these holds:
  - frame-done and interrupt enable bit 3
  - palette-done and interrupt enable bit 4
  - sync-error, with no enable needed
- R8: A control write that changes enable from 0 to 1 gives `startPulse` for exactly one cycle. A change from 1 to 0 gives `stopPulse` for exactly one cycle. A write that leaves enable unchanged gives no pulse.
- R9: When enable falls, sync-error is cleared. In the same write, frame-done is set unless the newly written palette-load mode is 1. Both effects win over a same-cycle set input.
- R10: When enable rises, frame-done and palette-done are cleared. This wins over same-cycle set inputs. Sync-error is untouched.
- R11: `frameDoneSet`, `paletteDoneSet` and `syncErrSet` set their flags, and the flags stay set until R9 or R10 clears them.
- R12: Reset clears every field and flag, so control reads 0xFE000C34 and status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | Write enable, qualified by busSel |
| busAddr | input | ADDR_W | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| frameDoneSet | input | 1 | Engine event: frame finished |
| paletteDoneSet | input | 1 | Engine event: palette loaded |
| syncErrSet | input | 1 | Engine event: sync error |
| pixWidthM1 | output | DIM_W | Width minus one |
| pixHeightM1 | output | DIM_W | Height minus one |
| palMode | output | 2 | Palette-load mode |
| tftMode | output | 1 | TFT panel select |
| monoMode | output | 1 | Monochrome select |
| panelOn | output | 1 | Controller enable |
| startPulse | output | 1 | One-cycle pulse when enable rises |
| stopPulse | output | 1 | One-cycle pulse when enable falls |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench targets stop writes made with palette-load mode 1 and with other modes. A design that reads the old mode would set or skip frame-done wrongly.

It also drives set inputs in the same cycle as start and stop writes. A design with the wrong priority would leave a stale flag or lose one. The bench rewrites enable at its current value, where a naive edge detector would emit spurious pulses. Finally, it checks that sync-error interrupts with both enables off and that the interrupt lags its flag by one cycle, which catches a combinational or ungated interrupt path.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;
  localparam int DATA_W = 32;

  localparam logic [31:0] CTRL_KEEP  = 32'h01CF_F300;
  localparam logic [31:0] CTRL_FORCE = 32'hFE00_0C34;
  localparam logic [31:0] T0_FORCE   = 32'h0000_000F;
  localparam logic [31:0] T2_FORCE   = 32'hFC00_0000;
  localparam logic [31:0] SUB_MASK   = 32'hA1FF_FFFF;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_DIMW = 8'h04;
  localparam logic [7:0] OFF_DIMH = 8'h08;
  localparam logic [7:0] OFF_TIM2 = 8'h0C;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_SUBP = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_DIMW, SEL_DIMH, SEL_TIM2, SEL_STAT, SEL_SUBP
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrDimW;
    logic    wrDimH;
    logic    wrTim2;
    logic    wrSubp;
    regSel_e rdSel;
  } busStb_t;
endpackage

// File: rtl/lcd_reg_ctrl.sv
module lcd_reg_ctrl
  import lcd_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busSel,
  input  logic              busWe,
  output busStb_t           stb
);
  regSel_e sel;
  logic    wrAny;

  always_comb begin
    sel = SEL_NONE;
    if (busAddr == ADDR_W'(OFF_CTRL)) sel = SEL_CTRL;
    if (busAddr == ADDR_W'(OFF_DIMW)) sel = SEL_DIMW;
    if (busAddr == ADDR_W'(OFF_DIMH)) sel = SEL_DIMH;
    if (busAddr == ADDR_W'(OFF_TIM2)) sel = SEL_TIM2;
    if (busAddr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    if (busAddr == ADDR_W'(OFF_SUBP)) sel = SEL_SUBP;
  end

  assign wrAny = busSel & busWe;

  always_comb begin
    stb.wrCtrl = wrAny && (sel == SEL_CTRL);
    stb.wrDimW = wrAny && (sel == SEL_DIMW);
    stb.wrDimH = wrAny && (sel == SEL_DIMH);
    stb.wrTim2 = wrAny && (sel == SEL_TIM2);
    stb.wrSubp = wrAny && (sel == SEL_SUBP);
    stb.rdSel  = sel;
  end
endmodule

// File: rtl/lcd_reg_dp.sv
module lcd_reg_dp
  import lcd_reg_pkg::*;
#(
  parameter int DIM_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStb_t           stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              frameDoneSet,
  input  logic              paletteDoneSet,
  input  logic              syncErrSet,
  output logic [DATA_W-1:0] busRdata,
  output logic [DIM_W-1:0]  pixWidthM1,
  output logic [DIM_W-1:0]  pixHeightM1,
  output logic [1:0]        palMode,
  output logic              tftMode,
  output logic              monoMode,
  output logic              panelOn,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              irqOut
);
  localparam int KEEP_W = DATA_W - DIM_W;

  logic [1:0]        intEn;
  logic [DATA_W-1:0] ctrlKeep, tim2Reg, subpReg;
  logic              frameDone, paletteDone, syncErr;
  logic              enRise, enFall, stopSetsFrame;
  logic [1:0]        dimWr;
  logic [DIM_W-1:0]  dimVal  [2];
  logic [KEEP_W-1:0] dimKeep [2];
  logic [DATA_W-1:0] dimRead [2];

  assign dimWr = {stb.wrDimH, stb.wrDimW};

  // Width and height words share one layout; index 0 = width, 1 = height.
  for (genvar g = 0; g < 2; g++) begin : g_dim
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dimVal[g]  <= '0;
        dimKeep[g] <= '0;
      end else if (dimWr[g]) begin
        dimVal[g]  <= busWdata[DIM_W-1:0];
        dimKeep[g] <= busWdata[DATA_W-1:DIM_W];
      end
    end
    assign dimRead[g] = {dimKeep[g], dimVal[g]};
  end

  assign enRise        = stb.wrCtrl &&  busWdata[0] && !panelOn;
  assign enFall        = stb.wrCtrl && !busWdata[0] &&  panelOn;
  assign stopSetsFrame = busWdata[21:20] != 2'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      palMode  <= '0;
      tftMode  <= 1'b0;
      monoMode <= 1'b0;
      panelOn  <= 1'b0;
      intEn    <= '0;
      ctrlKeep <= '0;
      tim2Reg  <= '0;
      subpReg  <= '0;
    end else begin
      if (stb.wrCtrl) begin
        palMode  <= busWdata[21:20];
        tftMode  <= busWdata[7];
        intEn    <= busWdata[4:3];
        monoMode <= busWdata[1];
        panelOn  <= busWdata[0];
        ctrlKeep <= busWdata & CTRL_KEEP;
      end
      if (stb.wrTim2) tim2Reg <= busWdata;
      if (stb.wrSubp) subpReg <= busWdata & SUB_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameDone   <= 1'b0;
      paletteDone <= 1'b0;
      syncErr     <= 1'b0;
      startPulse  <= 1'b0;
      stopPulse   <= 1'b0;
      irqOut      <= 1'b0;
    end else begin
      startPulse <= enRise;
      stopPulse  <= enFall;
      irqOut     <= (frameDone & intEn[0]) | (paletteDone & intEn[1]) | syncErr;
      if (enRise)                      frameDone <= 1'b0;
      else if (enFall && stopSetsFrame) frameDone <= 1'b1;
      else if (frameDoneSet)           frameDone <= 1'b1;
      if (enRise)              paletteDone <= 1'b0;
      else if (paletteDoneSet) paletteDone <= 1'b1;
      if (enFall)          syncErr <= 1'b0;
      else if (syncErrSet) syncErr <= 1'b1;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_CTRL: busRdata = ctrlKeep | CTRL_FORCE |
                           {8'b0, tftMode, 1'b0, palMode, 12'b0, tftMode,
                            2'b0, intEn, 1'b0, monoMode, panelOn};
      SEL_DIMW: busRdata = dimRead[0] | T0_FORCE;
      SEL_DIMH: busRdata = dimRead[1];
      SEL_TIM2: busRdata = tim2Reg | T2_FORCE;
      SEL_STAT: busRdata = {25'b0, paletteDone, 3'b0, syncErr, 1'b0, frameDone};
      SEL_SUBP: busRdata = subpReg;
      default:  busRdata = '0;
    endcase
  end

  assign pixWidthM1  = dimVal[0];
  assign pixHeightM1 = dimVal[1];
endmodule

// File: rtl/lcd_reg_unit.sv
module lcd_reg_unit
  import lcd_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              frameDoneSet,
  input  logic              paletteDoneSet,
  input  logic              syncErrSet,
  output logic [DIM_W-1:0]  pixWidthM1,
  output logic [DIM_W-1:0]  pixHeightM1,
  output logic [1:0]        palMode,
  output logic              tftMode,
  output logic              monoMode,
  output logic              panelOn,
  output logic              startPulse,
  output logic              stopPulse,
  output logic              irqOut
);
  busStb_t stb;

  lcd_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busSel(busSel), .busWe(busWe), .stb(stb)
  );

  lcd_reg_dp #(.DIM_W(DIM_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .frameDoneSet(frameDoneSet), .paletteDoneSet(paletteDoneSet),
    .syncErrSet(syncErrSet), .busRdata(busRdata),
    .pixWidthM1(pixWidthM1), .pixHeightM1(pixHeightM1),
    .palMode(palMode), .tftMode(tftMode), .monoMode(monoMode),
    .panelOn(panelOn), .startPulse(startPulse), .stopPulse(stopPulse),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/lcd_reg_chk.sv
module lcd_reg_chk
  import lcd_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              frameDoneSet,
  input logic              paletteDoneSet,
  input logic              syncErrSet,
  input logic [DIM_W-1:0]  pixWidthM1,
  input logic              panelOn,
  input logic              startPulse,
  input logic              stopPulse,
  input logic              irqOut
);
  logic atStat, anySet;
  assign atStat = busAddr == ADDR_W'(OFF_STAT);
  assign anySet = frameDoneSet | paletteDoneSet | syncErrSet;

  a_r8_start_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(panelOn) |-> startPulse);
  a_r8_stop_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(panelOn) |-> stopPulse);
  a_r8_never_both: assert property (@(posedge clk) disable iff (!rstN)
    !(startPulse && stopPulse));
  a_r7_sync_irq: assert property (@(posedge clk) disable iff (!rstN)
    (atStat && busRdata[2]) |=> irqOut);
  a_r5_status_ro: assert property (@(posedge clk) disable iff (!rstN)
    (atStat && busSel && busWe && !anySet) |=>
      (atStat -> busRdata[6:0] == $past(busRdata[6:0])));
  a_r3_width_load: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == ADDR_W'(OFF_DIMW)) |=>
      pixWidthM1 == $past(busWdata[DIM_W-1:0]));
endmodule

bind lcd_reg_unit lcd_reg_chk #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .frameDoneSet(frameDoneSet), .paletteDoneSet(paletteDoneSet),
  .syncErrSet(syncErrSet), .pixWidthM1(pixWidthM1), .panelOn(panelOn),
  .startPulse(startPulse), .stopPulse(stopPulse), .irqOut(irqOut)
);

// File: tb/lcd_reg_unit_bench.sv
`timescale 1ns/1ps
module lcd_reg_unit_bench;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0, busRdata;
  logic        fdSet = 1'b0, pdSet = 1'b0, seSet = 1'b0;
  logic [9:0]  pixW, pixH;
  logic [1:0]  palMode;
  logic        tftMode, monoMode, panelOn, startPulse, stopPulse, irqOut;
  int          total = 0, bad = 0;
  bit          fin = 1'b0;

  always #10 clk = ~clk;

  lcd_reg_unit u_lcd_reg_unit (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .frameDoneSet(fdSet), .paletteDoneSet(pdSet), .syncErrSet(seSet),
    .pixWidthM1(pixW), .pixHeightM1(pixH), .palMode(palMode),
    .tftMode(tftMode), .monoMode(monoMode), .panelOn(panelOn),
    .startPulse(startPulse), .stopPulse(stopPulse), .irqOut(irqOut)
  );

  // Behavioural reference state
  bit [31:0] mCtrl, mT0, mT1, mT2, mSub;
  bit        mFd, mPd, mSe, mIrq, mStart, mStop;

  function automatic bit [31:0] modelRead(input bit [7:0] a);
    case (a)
      8'h00: return mCtrl | 32'hFE00_0C34 | (32'(mCtrl[7]) << 23);
      8'h04: return mT0 | 32'hF;
      8'h08: return mT1;
      8'h0C: return mT2 | 32'hFC00_0000;
      8'h10: return {25'b0, mPd, 3'b0, mSe, 1'b0, mFd};
      8'h14: return mSub;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input bit [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04, 8'h08: return "R3";
      8'h0C, 8'h14: return "R4";
      8'h10: return "R5";
      default: return "R6";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mT0 = 0; mT1 = 0; mT2 = 0; mSub = 0;
      mFd = 0; mPd = 0; mSe = 0; mIrq = 0; mStart = 0; mStop = 0;
    end else begin
      bit wr, oldEn;
      mIrq = (mFd && mCtrl[3]) || (mPd && mCtrl[4]) || mSe;
      mStart = 0; mStop = 0;
      if (fdSet) mFd = 1;
      if (pdSet) mPd = 1;
      if (seSet) mSe = 1;
      wr = busSel && busWe;
      oldEn = mCtrl[0];
      if (wr) begin
        case (busAddr)
          8'h00: begin
            mCtrl = busWdata & (32'h01CF_F300 | 32'h0030_009B);
            if (busWdata[0] && !oldEn) begin
              mStart = 1; mFd = 0; mPd = 0;
            end else if (!busWdata[0] && oldEn) begin
              mStop = 1; mSe = 0;
              if (busWdata[21:20] != 2'd1) mFd = 1;
            end
          end
          8'h04: mT0 = busWdata;
          8'h08: mT1 = busWdata;
          8'h0C: mT2 = busWdata;
          8'h14: mSub = busWdata & 32'hA1FF_FFFF;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h @%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !fin) begin
      chk(tagFor(busAddr), busRdata, modelRead(busAddr));
      chk("R7 irq", 32'(irqOut), 32'(mIrq));
      chk("R8 start", 32'(startPulse), 32'(mStart));
      chk("R8 stop", 32'(stopPulse), 32'(mStop));
      chk("R3 dims", {pixH, pixW}, {mT1[9:0], mT0[9:0]});
      chk("R1 fields", {tftMode, monoMode, panelOn, palMode},
          {mCtrl[7], mCtrl[1], mCtrl[0], mCtrl[21:20]});
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask
  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    step();
    busSel = 0; busWe = 0;
  endtask
  task automatic rdChk(input string tag, input bit [7:0] a, input bit [31:0] exp);
    busAddr = a; #1;
    chk(tag, busRdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    rdChk("R12 ctrl", 8'h00, 32'hFE00_0C34);
    rdChk("R12 status", 8'h10, 32'h0);
    chk("R12 irq", 32'(irqOut), 32'h0);
    // full-ones control write
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R8 start pulse", 32'(startPulse), 32'h1);
    rdChk("R2 ctrl ones", 8'h00, 32'hFFFF_FFBF);
    step();
    chk("R8 start one cycle", 32'(startPulse), 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R8 no pulse same enable", 32'(startPulse | stopPulse), 32'h0);
    wr(8'h04, 32'h0000_0000); rdChk("R3 t0 forced", 8'h04, 32'h0000_000F);
    wr(8'h0C, 32'h0000_0001); rdChk("R4 t2", 8'h0C, 32'hFC00_0001);
    wr(8'h14, 32'hFFFF_FFFF); rdChk("R4 sub", 8'h14, 32'hA1FF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF); rdChk("R6 hole", 8'h18, 32'h0);
    // R9: stop with mode 0 sets frame-done, clears sync-error
    wr(8'h00, 32'h0000_0000);
    wr(8'h00, 32'h0000_0001);
    seSet = 1; step(); seSet = 0;
    step();
    chk("R7 sync irq no enable", 32'(irqOut), 32'h1);
    wr(8'h00, 32'h0000_0000);
    rdChk("R9 stop mode0", 8'h10, 32'h0000_0001);
    // R9: stop with mode 1 leaves frame-done clear
    wr(8'h00, 32'h0010_0001);
    wr(8'h00, 32'h0010_0000);
    rdChk("R9 stop mode1", 8'h10, 32'h0);
    // R11 / R10
    wr(8'h00, 32'h0000_0001);
    fdSet = 1; pdSet = 1; step(); fdSet = 0; pdSet = 0;
    rdChk("R11 flags", 8'h10, 32'h0000_0041);
    wr(8'h10, 32'h0);
    rdChk("R5 status write ignored", 8'h10, 32'h0000_0041);
    wr(8'h00, 32'h0000_0000);
    fdSet = 1; pdSet = 1;
    wr(8'h00, 32'h0000_0001);
    fdSet = 0; pdSet = 0;
    rdChk("R10 start clears", 8'h10, 32'h0);
    // R7: gated frame-done interrupt, one-cycle lag
    wr(8'h00, 32'h0000_0009);
    fdSet = 1; step(); fdSet = 0;
    chk("R7 lag", 32'(irqOut), 32'h0);
    step();
    chk("R7 frame irq", 32'(irqOut), 32'h1);
    // mixed random traffic, compared each cycle against the model
    for (int i = 0; i < 600; i++) begin
      bit [7:0] offs [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h3C};
      busAddr  = offs[$urandom % 8];
      busSel   = ($urandom % 3) != 0;
      busWe    = ($urandom % 2) != 0;
      busWdata = $urandom;
      fdSet    = ($urandom % 6) == 0;
      pdSet    = ($urandom % 6) == 0;
      seSet    = ($urandom % 9) == 0;
      step();
    end
    busSel = 0; busWe = 0; fdSet = 0; pdSet = 0; seSet = 0;
    step();
    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule